// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration and status state of a four-bank SDRAM controller. Software never addresses its registers directly. It first writes an internal register offset into a selector port. It then reads or writes the chosen register through a second data port. Each data register applies its own write mask and its own side effects. These cover write-one-to-clear error flags, read-only status, forced bit patterns, and flags that track transitions of the controller enable.

The block turns the four bank configuration registers into a base, a size and an enable for each bank. It decodes any physical address against them and returns a one-hot bank hit vector and a no-hit flag. It also drives an interrupt line that is high exactly while the stored ECC error status is nonzero. DRAM command sequencing and the memory array are handled elsewhere.

Top module: `sdram_cfg_regs`

## Requirements
- R1: On reset the selector port reads 0, config reads 0x00800000, refresh reads 0x05F00000, power-management reads 0x07C00000, and status, error, bank, ECC config and ECC error status registers read 0. The interrupt is low.
- R2: Port select 0 is the selector and port select 1 is the data port. A selector write stores all 32 bits and reads them back. A data access acts on the register whose offset equals the stored selector value. Offsets: 0x00/0x08 error status, 0x10 error address, 0x20 config, 0x24 status, 0x30 refresh, 0x34 power-management, 0x40/0x44/0x48/0x4C banks 0..3, 0x80 timing, 0x94 ECC config, 0x98 ECC error status.
- R3: Any offset not in that list reads 0xFFFFFFFF, and writes to it change nothing.
- R4: Masked writes. Refresh keeps bits under 0x3FF80000. Power-management stores written bits 31:27 with bits 26:22 forced to 1. ECC config keeps bits 23:20. Bank registers keep bits under 0xFFDEE001. The error address register stores the full word.
- R5: Timing writes are accepted, but a timing read always returns 0xFFFFFFFF.
- R6: The two error status registers are write-one-to-clear. Status ignores writes.
- R7: Config keeps only bits 31:21. When config bit 31 goes 0 to 1, status bit 31 clears. When it goes 1 to 0, status bit 31 sets. Status bit 30 follows the 0 to 1 and 1 to 0 changes of config bit 30. No other status bit is ever set.
- R8: A bank hits an address only when config bit 31 is set, bank bit 0 is set, and the size code (bank bits 19:17) is not 7. The address must also satisfy base <= addr < base + (4 MiB << code), where base is bank bits 31:23 followed by 23 zero bits. This comparison is made without 32-bit wraparound.
- R9: The hit vector is one-hot. When several banks hit, the lowest-numbered bank wins. The no-hit flag is high exactly when no bank hits.
- R10: ECC error status writes keep bits under 0xFFF0F000. The interrupt rises in the cycle after the stored value becomes nonzero and falls in the cycle after it becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_port | input | 1 | 0 selector port, 1 data port |
| acc_we | input | 1 | Write enable for the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the port selected by acc_port (combinational) |
| probe_addr | input | 32 | Physical address to decode |
| bank_hit | output | 4 | One-hot bank hit |
| bank_miss | output | 1 | No bank hits probe_addr |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A corrupted selector value shows on the next read through either port. A stored mask fault appears on the readback right after the write. A broken status flag shows in the status read that follows the config write that should have toggled it. Bank decode is combinational from the stored registers. A wrong base, size or enable therefore changes bank_hit within the same cycle that probe_addr is applied. The most telling probes are the last address inside a window, the first address past it, and the top of the 32-bit space. An interrupt fault shows one cycle after the ECC error status write.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DW      = 32;
  localparam int NBANK   = 4;
  localparam int BASE_W  = 9;
  localparam int CODE_W  = 3;
  localparam int SPAN_W  = DW + 1;

  localparam logic [DW-1:0] OFS_ERRST0 = 32'h00;
  localparam logic [DW-1:0] OFS_ERRST1 = 32'h08;
  localparam logic [DW-1:0] OFS_ERRADR = 32'h10;
  localparam logic [DW-1:0] OFS_CFG    = 32'h20;
  localparam logic [DW-1:0] OFS_STS    = 32'h24;
  localparam logic [DW-1:0] OFS_RFSH   = 32'h30;
  localparam logic [DW-1:0] OFS_PMGT   = 32'h34;
  localparam logic [DW-1:0] OFS_BANK0  = 32'h40;
  localparam logic [DW-1:0] OFS_TIMING = 32'h80;
  localparam logic [DW-1:0] OFS_ECCCFG = 32'h94;
  localparam logic [DW-1:0] OFS_ECCERR = 32'h98;

  localparam logic [DW-1:0] MSK_CFG    = 32'hFFE00000;
  localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF80000;
  localparam logic [DW-1:0] MSK_PMGT   = 32'hF8000000;
  localparam logic [DW-1:0] SET_PMGT   = 32'h07C00000;
  localparam logic [DW-1:0] MSK_BANK   = 32'hFFDEE001;
  localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F00000;
  localparam logic [DW-1:0] MSK_ECCERR = 32'hFFF0F000;

  localparam logic [DW-1:0] RST_CFG    = 32'h00800000;
  localparam logic [DW-1:0] RST_RFSH   = 32'h05F00000;
  localparam logic [DW-1:0] RST_PMGT   = 32'h07C00000;

  localparam logic [CODE_W-1:0] CODE_BAD = 3'd7;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              en;
  } bank_fld_t;

  function automatic logic [SPAN_W-1:0] win_size(input logic [CODE_W-1:0] code);
    return SPAN_W'(33'h0040_0000) << code;
  endfunction

  function automatic logic [SPAN_W-1:0] win_base(input logic [BASE_W-1:0] b);
    return {1'b0, b, {(DW-BASE_W){1'b0}}};
  endfunction

  function automatic logic addr_inside(input logic [DW-1:0] a, input bank_fld_t f);
    logic [SPAN_W-1:0] lo, hi, ax;
    lo = win_base(f.base);
    hi = lo + win_size(f.code);
    ax = {1'b0, a};
    return (ax >= lo) && (ax < hi);
  endfunction
endpackage

// File: rtl/sdram_bank_match.sv
module sdram_bank_match
  import sdram_cfg_pkg::*;
(
  input  logic       ctrl_en,
  input  bank_fld_t  fld,
  input  logic [DW-1:0] addr,
  output logic       hit
);
  logic usable;
  assign usable = ctrl_en && fld.en && (fld.code != CODE_BAD);
  assign hit    = usable && addr_inside(addr, fld);
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_port,
  input  logic          acc_we,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output bank_fld_t [NBANK-1:0] bank_fld,
  output logic          ctrl_en,
  output logic [1:0]    sts_flags,
  output logic          ecc_nz,
  output logic          ecc_wr_evt,
  output logic          sts_wr_evt
);
  logic [DW-1:0] sel_q, errst0_q, errst1_q, erradr_q, cfg_q;
  logic [DW-1:0] rfsh_q, pmgt_q, ecccfg_q, eccerr_q;
  logic [DW-1:0] bank_q [NBANK];
  logic [1:0]    sts_q;
  logic [DW-1:0] cfg_nx;
  logic          wr_sel, wr_dat;
  logic [DW-1:0] dat_rd;

  assign wr_sel     = acc_en && acc_we && !acc_port;
  assign wr_dat     = acc_en && acc_we &&  acc_port;
  assign ecc_wr_evt = wr_dat && (sel_q == OFS_ECCERR);
  assign sts_wr_evt = wr_dat && (sel_q == OFS_STS);
  assign cfg_nx     = acc_wdata & MSK_CFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      errst0_q <= '0;
      errst1_q <= '0;
      erradr_q <= '0;
      cfg_q    <= RST_CFG;
      sts_q    <= '0;
      rfsh_q   <= RST_RFSH;
      pmgt_q   <= RST_PMGT;
      ecccfg_q <= '0;
      eccerr_q <= '0;
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
    end else begin
      if (wr_sel) sel_q <= acc_wdata;
      if (wr_dat) begin
        case (sel_q)
          OFS_ERRST0: errst0_q <= errst0_q & ~acc_wdata;
          OFS_ERRST1: errst1_q <= errst1_q & ~acc_wdata;
          OFS_ERRADR: erradr_q <= acc_wdata;
          OFS_CFG: begin
            if (!cfg_q[31] && cfg_nx[31]) sts_q[1] <= 1'b0;
            else if (cfg_q[31] && !cfg_nx[31]) sts_q[1] <= 1'b1;
            if (!cfg_q[30] && cfg_nx[30]) sts_q[0] <= 1'b1;
            else if (cfg_q[30] && !cfg_nx[30]) sts_q[0] <= 1'b0;
            cfg_q <= cfg_nx;
          end
          OFS_RFSH:   rfsh_q   <= acc_wdata & MSK_RFSH;
          OFS_PMGT:   pmgt_q   <= (acc_wdata & MSK_PMGT) | SET_PMGT;
          OFS_ECCCFG: ecccfg_q <= acc_wdata & MSK_ECCCFG;
          OFS_ECCERR: eccerr_q <= acc_wdata & MSK_ECCERR;
          default: begin
            for (int i = 0; i < NBANK; i++)
              if (sel_q == OFS_BANK0 + DW'(4 * i)) bank_q[i] <= acc_wdata & MSK_BANK;
          end
        endcase
      end
    end
  end

  always_comb begin
    dat_rd = '1;
    case (sel_q)
      OFS_ERRST0: dat_rd = errst0_q;
      OFS_ERRST1: dat_rd = errst1_q;
      OFS_ERRADR: dat_rd = erradr_q;
      OFS_CFG:    dat_rd = cfg_q;
      OFS_STS:    dat_rd = {sts_q, {(DW-2){1'b0}}};
      OFS_RFSH:   dat_rd = rfsh_q;
      OFS_PMGT:   dat_rd = pmgt_q;
      OFS_TIMING: dat_rd = '1;
      OFS_ECCCFG: dat_rd = ecccfg_q;
      OFS_ECCERR: dat_rd = eccerr_q;
      default: begin
        for (int i = 0; i < NBANK; i++)
          if (sel_q == OFS_BANK0 + DW'(4 * i)) dat_rd = bank_q[i];
      end
    endcase
  end

  assign acc_rdata = acc_port ? dat_rd : sel_q;

  for (genvar g = 0; g < NBANK; g++) begin : g_fld
    assign bank_fld[g].base = bank_q[g][31:23];
    assign bank_fld[g].code = bank_q[g][19:17];
    assign bank_fld[g].en   = bank_q[g][0];
  end

  assign ctrl_en   = cfg_q[31];
  assign sts_flags = sts_q;
  assign ecc_nz    = |eccerr_q;
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_port,
  input  logic          acc_we,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  input  logic [31:0]   probe_addr,
  output logic [3:0]    bank_hit,
  output logic          bank_miss,
  output logic          ecc_irq
);
  bank_fld_t [NBANK-1:0] bank_fld;
  logic             ctrl_en;
  logic [1:0]       sts_flags;
  logic             ecc_nz;
  logic             ecc_wr_evt;
  logic             sts_wr_evt;
  logic [NBANK-1:0] raw_hit;

  sdram_cfg_regfile u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_port   (acc_port),
    .acc_we     (acc_we),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .bank_fld   (bank_fld),
    .ctrl_en    (ctrl_en),
    .sts_flags  (sts_flags),
    .ecc_nz     (ecc_nz),
    .ecc_wr_evt (ecc_wr_evt),
    .sts_wr_evt (sts_wr_evt)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdram_bank_match u_match (
      .ctrl_en (ctrl_en),
      .fld     (bank_fld[g]),
      .addr    (probe_addr),
      .hit     (raw_hit[g])
    );
  end

  // lowest index wins: isolate the least significant set bit
  assign bank_hit  = raw_hit & (~raw_hit + NBANK'(1));
  assign bank_miss = (raw_hit == '0);
  assign ecc_irq   = ecc_nz;
endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bank_hit,
  input logic       ecc_irq,
  input logic       ctrl_en,
  input logic [1:0] sts_flags,
  input logic       ecc_wr_evt,
  input logic       sts_wr_evt
);
  // R9
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));

  // R8
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (bank_hit == 4'b0));

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_irq) |-> $past(ecc_wr_evt));

  // R10
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ecc_irq) |-> $past(ecc_wr_evt));

  // R6
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_evt |=> $stable(sts_flags));

  // R7
  enable_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> !sts_flags[1]);

  // R7
  disable_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> sts_flags[1]);
endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_hit   (bank_hit),
  .ecc_irq    (ecc_irq),
  .ctrl_en    (ctrl_en),
  .sts_flags  (sts_flags),
  .ecc_wr_evt (ecc_wr_evt),
  .sts_wr_evt (sts_wr_evt)
);

// File: tb/sdram_cfg_regs_test.sv
module sdram_cfg_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_port = 1'b0, acc_we = 1'b0;
  logic [31:0] acc_wdata = '0, probe_addr = '0;
  logic [31:0] acc_rdata;
  logic [3:0]  bank_hit;
  logic        bank_miss, ecc_irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdram_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_port(acc_port),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .probe_addr(probe_addr), .bank_hit(bank_hit), .bank_miss(bank_miss),
    .ecc_irq(ecc_irq)
  );

  // offset, write value, expected readback
  localparam int NV = 12;
  localparam logic [95:0] VEC [NV] = '{
    {32'h30, 32'hFFFFFFFF, 32'h3FF80000},
    {32'h34, 32'hFFFFFFFF, 32'hFFC00000},
    {32'h34, 32'h00000000, 32'h07C00000},
    {32'h10, 32'h12345678, 32'h12345678},
    {32'h94, 32'hFFFFFFFF, 32'h00F00000},
    {32'h80, 32'h00000000, 32'hFFFFFFFF},
    {32'h24, 32'hFFFFFFFF, 32'h00000000},
    {32'h44, 32'hFFFFFFFF, 32'hFFDEE001},
    {32'h00, 32'hFFFFFFFF, 32'h00000000},
    {32'h08, 32'hFFFFFFFF, 32'h00000000},
    {32'h60, 32'h00000000, 32'hFFFFFFFF},
    {32'h44, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_port = port; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic wreg(input logic [31:0] ofs, input logic [31:0] d);
    wr(1'b0, ofs);
    wr(1'b1, d);
  endtask

  task automatic rreg(input logic [31:0] ofs, output logic [31:0] d);
    wr(1'b0, ofs);
    acc_port = 1; #1 d = acc_rdata;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [4:0] exp);
    probe_addr = a; #1;
    chk(req, {27'd0, bank_miss, bank_hit}, {27'd0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    acc_port = 0; #1 chk("R1 sel", acc_rdata, 0);
    rreg(32'h20, d); chk("R1 cfg", d, 32'h00800000);
    rreg(32'h30, d); chk("R1 rfsh", d, 32'h05F00000);
    rreg(32'h34, d); chk("R1 pmgt", d, 32'h07C00000);
    rreg(32'h24, d); chk("R1 sts", d, 0);
    rreg(32'h4C, d); chk("R1 bank3", d, 0);
    rreg(32'h98, d); chk("R1 eccerr", d, 0);
    rreg(32'h94, d); chk("R1 ecccfg", d, 0);
    chk("R1 irq", {31'd0, ecc_irq}, 0);
    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wreg(VEC[i][95:64], VEC[i][63:32]);
      rreg(VEC[i][95:64], d);
      chk($sformatf("R2/R4 vec%0d", i), d, VEC[i][31:0]);
    end
    acc_port = 0; #1 chk("R2 sel readback", acc_rdata, 32'h44);
    rreg(32'h60, d); chk("R3 unmapped", d, 32'hFFFFFFFF);
    rreg(32'h80, d); chk("R5 timing", d, 32'hFFFFFFFF);
    // R7 status tracking
    wreg(32'h20, 32'h80000000); rreg(32'h24, d); chk("R7 en", d, 0);
    wreg(32'h20, 32'h00000000); rreg(32'h24, d); chk("R7 dis", d, 32'h80000000);
    wreg(32'h20, 32'h40000000); rreg(32'h24, d); chk("R7 b30 set", d, 32'hC0000000);
    wreg(32'h20, 32'hC0000000); rreg(32'h24, d); chk("R7 re-en", d, 32'h40000000);
    wreg(32'h20, 32'h80000000); rreg(32'h24, d); chk("R7 b30 clr", d, 0);
    wreg(32'h24, 32'hFFFFFFFF); rreg(32'h24, d); chk("R6 sts ro", d, 0);
    // R8 R9 bank decode (controller enabled)
    wreg(32'h40, 32'h00040001);
    wreg(32'h44, 32'h01000001);
    wreg(32'h48, 32'h100E0001);
    wreg(32'h4C, 32'h20000000);
    probe("R8 b0 last", 32'h00FFFFFF, 5'b00001);
    probe("R8 b1 first", 32'h01000000, 5'b00010);
    probe("R8 b1 last", 32'h013FFFFF, 5'b00010);
    probe("R8 past b1", 32'h01400000, 5'b10000);
    probe("R8 code7", 32'h10000000, 5'b10000);
    probe("R8 bank off", 32'h20000000, 5'b10000);
    wreg(32'h4C, 32'h00000001);
    probe("R9 overlap", 32'h00000010, 5'b00001);
    wreg(32'h40, 32'hFF8C0001);
    probe("R9 b3 alone", 32'h00000010, 5'b01000);
    probe("R8 top", 32'hFFFFFFFF, 5'b00001);
    probe("R8 below top", 32'hFF7FFFFF, 5'b10000);
    wreg(32'h20, 32'h00000000);
    probe("R8 ctrl off", 32'hFFFFFFFF, 5'b10000);
    // R7 config mask
    wreg(32'h20, 32'hFFFFFFFF); rreg(32'h20, d); chk("R7 cfg mask", d, 32'hFFE00000);
    rreg(32'h24, d); chk("R7 sts both", d, 32'h40000000);
    // R10 ECC interrupt
    wreg(32'h98, 32'h00000FFF); rreg(32'h98, d); chk("R10 masked", d, 0);
    chk("R10 irq low", {31'd0, ecc_irq}, 0);
    wreg(32'h98, 32'h00001000);
    chk("R10 irq high", {31'd0, ecc_irq}, 1);
    rreg(32'h98, d); chk("R10 stored", d, 32'h00001000);
    wreg(32'h98, 32'h0);
    chk("R10 irq fall", {31'd0, ecc_irq}, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule